// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines may interrupt the processor. It keeps the in-service register and a 3-bit rotation base, takes the already-captured request vector and the mask register from outside, and raises a registered interrupt line whenever the best unmasked request outranks everything now in service. Priority is circular: the line equal to the rotation base ranks highest, and rank falls as the line number climbs, wrapping past 7 back to 0.

When the processor acknowledges, the block names the winning line and forms an 8-bit vector from a 5-bit vector base in the upper bits and the line in the low three bits. Depending on the mode flags, it then marks the line in service, or, with automatic end-of-interrupt, leaves the in-service register alone and may rotate the base. End-of-interrupt and priority commands arrive on a small command port. These commands clear in-service bits and can move the base. Special mask mode and nested mode on a cascade master change which in-service bits count as blocking.

Top module: `rotprio_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `irq_o` is 0, `isr_o` is 0, `prio_base_o` is 0 and `ack_valid_o` is 0.
- R2: Line `prio_base_o` has the highest priority. Rank drops with each step up in line number modulo 8, so the line just below the base ranks lowest.
- R3: The candidates are `req_i & ~mask_i`. An interrupt is due only when the best candidate strictly outranks the highest-ranked blocking in-service bit. A request on a line that is already in service is not due.
- R4: With `spec_mask_i` high, in-service bits of masked lines do not block.
- R5: With `nest_skip_i` and `is_master_i` both high, in-service bit 2 does not block. With `is_master_i` low, bit 2 blocks as usual.
- R6: An acknowledge (`ack_i`) while an interrupt is due with `auto_eoi_i` low sets the winner's in-service bit. One cycle later it reports `ack_valid_o`=1, `ack_spur_o`=0, `ack_line_o` set to the winner, and `ack_vec_o = {vec_base_i, line}`.
- R7: An acknowledge with `auto_eoi_i` high sets no in-service bit. If `rot_aeoi_i` is also high, the base becomes the winner plus 1 modulo 8.
- R8: Command code 1 clears the highest-ranked in-service bit, taken from the full in-service register. Code 5 does the same and also sets the base to that line plus 1. With no bit in service, neither code changes anything.
- R9: Code 3 clears the in-service bit given by `cmd_line_i`. Code 7 also sets the base to that line plus 1. Code 6 sets the base to `cmd_line_i`+1 and leaves the in-service bits alone. Codes 0, 2 and 4 change nothing.
- R10: An acknowledge with nothing due reports `ack_spur_o`=1, line 7 and vector `{vec_base_i, 3'd7}`, and changes no state.
- R11: `irq_o` is registered. After each clock edge it shows the due condition computed from the state and inputs that were present before that edge.
- R12: A command whose `cmd_valid_i` coincides with `ack_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Captured request vector |
| mask_i | input | 8 | Mask register, 1 disables a line |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| spec_mask_i | input | 1 | Special mask mode |
| nest_skip_i | input | 1 | Special fully nested mode |
| is_master_i | input | 1 | Instance is the cascade master |
| vec_base_i | input | 5 | Upper five bits of the vector |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_line_i | input | 3 | Line field of the command |
| irq_o | output | 1 | Registered interrupt line |
| ack_valid_o | output | 1 | Acknowledge result valid |
| ack_spur_o | output | 1 | Acknowledge found nothing due |
| ack_line_o | output | 3 | Acknowledged line |
| ack_vec_o | output | 8 | Vector number |
| isr_o | output | 8 | In-service register |
| prio_base_o | output | 3 | Rotation base |

## Verification
The hardest state to reach from the ports combines a rotated base, several in-service bits, and a special mode that hides some of those bits. In that state the blocking rank comes from a different bit than the one a plain end-of-interrupt would clear. Random stimulus reaches it because acknowledges are frequent and end-of-interrupt commands are rarer, so in-service bits pile up while the rotate and set-priority codes move the base. Directed steps before the random phase cover the empty end-of-interrupt, the spurious acknowledge, and an acknowledge that coincides with a command.

// File: rtl/rotprio_pkg.sv
package rotprio_pkg;

    localparam int LW     = 3;
    localparam int NLINES = 1 << LW;
    localparam int VEC_W  = 8;
    localparam int VB_W   = VEC_W - LW;
    localparam int NSCAN  = 3;

    typedef logic [NLINES-1:0] linevec_t;
    typedef logic [LW-1:0]     line_t;

    // command codes; bit pattern is decoded by the command source
    typedef enum logic [2:0] {
        CMD_IDLE0      = 3'd0,
        CMD_EOI_NS     = 3'd1,
        CMD_IDLE2      = 3'd2,
        CMD_EOI_SP     = 3'd3,
        CMD_IDLE4      = 3'd4,
        CMD_EOI_NS_ROT = 3'd5,
        CMD_SETPRIO    = 3'd6,
        CMD_EOI_SP_ROT = 3'd7
    } cmd_e;

    typedef struct packed {
        logic  found;
        line_t line;
        line_t rank;
    } scan_t;

    typedef struct packed {
        logic auto_eoi;
        logic rot_aeoi;
        logic spec_mask;
        logic nest_skip;
        logic is_master;
    } mode_t;

    // scan slots
    localparam int SC_CAND = 0;
    localparam int SC_EFF  = 1;
    localparam int SC_RAW  = 2;

    localparam int CASCADE_LINE = 2;

    function automatic line_t next_line(input line_t l);
        return l + line_t'(1);
    endfunction

endpackage

// File: rtl/rotprio_scan.sv
module rotprio_scan #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [W-1:0] base_i,
    input  logic [N-1:0] set_i,
    output logic         found_o,
    output logic [W-1:0] line_o,
    output logic [W-1:0] rank_o
);
    // walk from lowest rank upward, last hit in a descending loop wins
    always_comb begin
        found_o = 1'b0;
        line_o  = '0;
        rank_o  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [W-1:0] idx;
            idx = base_i + W'(k);
            if (set_i[idx]) begin
                found_o = 1'b1;
                line_o  = idx;
                rank_o  = W'(k);
            end
        end
    end
endmodule

// File: rtl/rotprio_judge.sv
module rotprio_judge
    import rotprio_pkg::*;
(
    input  linevec_t req_i,
    input  linevec_t mask_i,
    input  linevec_t isr_i,
    input  line_t    base_i,
    input  mode_t    mode_i,
    output logic     due_o,
    output line_t    win_line_o,
    output scan_t    top_isr_o
);
    linevec_t scan_set [NSCAN];
    scan_t    scan_res [NSCAN];
    linevec_t block_keep;

    always_comb begin
        block_keep = '1;
        if (mode_i.spec_mask)
            block_keep = block_keep & ~mask_i;
        if (mode_i.nest_skip && mode_i.is_master)
            block_keep[CASCADE_LINE] = 1'b0;
    end

    assign scan_set[SC_CAND] = req_i & ~mask_i;
    assign scan_set[SC_EFF]  = isr_i & block_keep;
    assign scan_set[SC_RAW]  = isr_i;

    for (genvar g = 0; g < NSCAN; g++) begin : g_scan
        rotprio_scan #(.N(NLINES), .W(LW)) u_scan (
            .base_i  (base_i),
            .set_i   (scan_set[g]),
            .found_o (scan_res[g].found),
            .line_o  (scan_res[g].line),
            .rank_o  (scan_res[g].rank)
        );
    end

    assign due_o = scan_res[SC_CAND].found &&
                   (!scan_res[SC_EFF].found ||
                    (scan_res[SC_CAND].rank < scan_res[SC_EFF].rank));
    assign win_line_o = scan_res[SC_CAND].line;
    assign top_isr_o  = scan_res[SC_RAW];
endmodule

// File: rtl/rotprio_state.sv
module rotprio_state
    import rotprio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_i,
    input  logic     due_i,
    input  line_t    win_line_i,
    input  mode_t    mode_i,
    input  logic     cmd_valid_i,
    input  cmd_e     cmd_op_i,
    input  line_t    cmd_line_i,
    input  scan_t    top_isr_i,
    output linevec_t isr_o,
    output line_t    base_o
);
    linevec_t isr_q, isr_n;
    line_t    base_q, base_n;

    always_comb begin
        isr_n  = isr_q;
        base_n = base_q;
        if (ack_i) begin
            if (due_i) begin
                if (!mode_i.auto_eoi)
                    isr_n[win_line_i] = 1'b1;
                else if (mode_i.rot_aeoi)
                    base_n = next_line(win_line_i);
            end
        end else if (cmd_valid_i) begin
            unique case (cmd_op_i)
                CMD_EOI_NS: begin
                    if (top_isr_i.found)
                        isr_n[top_isr_i.line] = 1'b0;
                end
                CMD_EOI_NS_ROT: begin
                    if (top_isr_i.found) begin
                        isr_n[top_isr_i.line] = 1'b0;
                        base_n = next_line(top_isr_i.line);
                    end
                end
                CMD_EOI_SP: isr_n[cmd_line_i] = 1'b0;
                CMD_EOI_SP_ROT: begin
                    isr_n[cmd_line_i] = 1'b0;
                    base_n = next_line(cmd_line_i);
                end
                CMD_SETPRIO: base_n = next_line(cmd_line_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= isr_n;
            base_q <= base_n;
        end
    end

    assign isr_o  = isr_q;
    assign base_o = base_q;
endmodule

// File: rtl/rotprio_ctrl.sv
module rotprio_ctrl
    import rotprio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NLINES-1:0] req_i,
    input  logic [NLINES-1:0] mask_i,
    input  logic             auto_eoi_i,
    input  logic             rot_aeoi_i,
    input  logic             spec_mask_i,
    input  logic             nest_skip_i,
    input  logic             is_master_i,
    input  logic [VB_W-1:0]  vec_base_i,
    input  logic             ack_i,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [LW-1:0]    cmd_line_i,
    output logic             irq_o,
    output logic             ack_valid_o,
    output logic             ack_spur_o,
    output logic [LW-1:0]    ack_line_o,
    output logic [VEC_W-1:0] ack_vec_o,
    output logic [NLINES-1:0] isr_o,
    output logic [LW-1:0]    prio_base_o
);
    mode_t    mode;
    logic     due;
    line_t    win_line;
    scan_t    top_isr;
    linevec_t isr_cur;
    line_t    base_cur;
    line_t    ack_line_n;

    logic     irq_q, ackv_q, spur_q;
    line_t    ackl_q;
    logic [VEC_W-1:0] vec_q;

    assign mode = '{auto_eoi:  auto_eoi_i,
                    rot_aeoi:  rot_aeoi_i,
                    spec_mask: spec_mask_i,
                    nest_skip: nest_skip_i,
                    is_master: is_master_i};

    rotprio_judge u_judge (
        .req_i      (req_i),
        .mask_i     (mask_i),
        .isr_i      (isr_cur),
        .base_i     (base_cur),
        .mode_i     (mode),
        .due_o      (due),
        .win_line_o (win_line),
        .top_isr_o  (top_isr)
    );

    rotprio_state u_state (
        .clk         (clk),
        .rst         (rst),
        .ack_i       (ack_i),
        .due_i       (due),
        .win_line_i  (win_line),
        .mode_i      (mode),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_e'(cmd_op_i)),
        .cmd_line_i  (cmd_line_i),
        .top_isr_i   (top_isr),
        .isr_o       (isr_cur),
        .base_o      (base_cur)
    );

    // nothing due: report the lowest line as spurious
    assign ack_line_n = due ? win_line : line_t'(NLINES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            ackv_q <= 1'b0;
            spur_q <= 1'b0;
            ackl_q <= '0;
            vec_q  <= '0;
        end else begin
            irq_q  <= due;
            ackv_q <= ack_i;
            if (ack_i) begin
                spur_q <= !due;
                ackl_q <= ack_line_n;
                vec_q  <= {vec_base_i, ack_line_n};
            end
        end
    end

    assign irq_o       = irq_q;
    assign ack_valid_o = ackv_q;
    assign ack_spur_o  = spur_q;
    assign ack_line_o  = ackl_q;
    assign ack_vec_o   = vec_q;
    assign isr_o       = isr_cur;
    assign prio_base_o = base_cur;
endmodule

// File: rtl/rotprio_chk.sv
module rotprio_chk
    import rotprio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NLINES-1:0] req_i,
    input logic [NLINES-1:0] mask_i,
    input logic             auto_eoi_i,
    input logic [VB_W-1:0]  vec_base_i,
    input logic             ack_i,
    input logic             cmd_valid_i,
    input logic [2:0]       cmd_op_i,
    input logic [LW-1:0]    cmd_line_i,
    input logic             irq_o,
    input logic             ack_valid_o,
    input logic             ack_spur_o,
    input logic [LW-1:0]    ack_line_o,
    input logic [VEC_W-1:0] ack_vec_o,
    input logic [NLINES-1:0] isr_o,
    input logic [LW-1:0]    prio_base_o
);
    // R11
    irq_needs_cand_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(req_i & ~mask_i) != '0));

    // R6
    ack_marks_service_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_o && !ack_spur_o && !$past(auto_eoi_i)) |-> isr_o[ack_line_o]);

    // R6
    vec_layout_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> (ack_vec_o == {$past(vec_base_i), ack_line_o}));

    // R10
    spurious_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_o && ack_spur_o) |->
        (isr_o == $past(isr_o) && prio_base_o == $past(prio_base_o) &&
         ack_line_o == LW'(NLINES - 1)));

    // R7
    auto_eoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ack_i && auto_eoi_i) |-> (isr_o == $past(isr_o)));

    // R8
    empty_eoi_noop_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid_i && !ack_i && cmd_op_i[0] && !cmd_op_i[1] && isr_o == '0)
        |-> (isr_o == '0 && prio_base_o == $past(prio_base_o)));

    // R9
    setprio_base_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid_i && !ack_i && cmd_op_i == 3'd6) |->
        (isr_o == $past(isr_o) && prio_base_o == $past(cmd_line_i) + LW'(1)));
endmodule

bind rotprio_ctrl rotprio_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .mask_i      (mask_i),
    .auto_eoi_i  (auto_eoi_i),
    .vec_base_i  (vec_base_i),
    .ack_i       (ack_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_line_i  (cmd_line_i),
    .irq_o       (irq_o),
    .ack_valid_o (ack_valid_o),
    .ack_spur_o  (ack_spur_o),
    .ack_line_o  (ack_line_o),
    .ack_vec_o   (ack_vec_o),
    .isr_o       (isr_o),
    .prio_base_o (prio_base_o)
);

// File: tb/rotprio_ctrl_test.sv
`timescale 1ns/1ps
module rotprio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0, mask_i = '0;
    logic       auto_eoi_i = 0, rot_aeoi_i = 0, spec_mask_i = 0;
    logic       nest_skip_i = 0, is_master_i = 0;
    logic [4:0] vec_base_i = '0;
    logic       ack_i = 0, cmd_valid_i = 0;
    logic [2:0] cmd_op_i = '0, cmd_line_i = '0;
    logic       irq_o, ack_valid_o, ack_spur_o;
    logic [2:0] ack_line_o, prio_base_o;
    logic [7:0] ack_vec_o, isr_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_isr = '0;
    int         m_base = 0;

    rotprio_ctrl uut (.*);

    always #10 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int first_hit(logic [7:0] s, int b);
        for (int k = 0; k < 8; k++)
            if (s[(b + k) % 8]) return (b + k) % 8;
        return -1;
    endfunction

    function automatic int rank_at(int line, int b);
        return (line < 0) ? 8 : (line - b + 8) % 8;
    endfunction

    function automatic bit is_due(logic [7:0] rq, logic [7:0] mk, logic sm,
                                  logic ns, logic ms, output int win);
        logic [7:0] blk = m_isr;
        if (sm) blk = blk & ~mk;
        if (ns && ms) blk[2] = 1'b0;
        win = first_hit(rq & ~mk, m_base);
        return (win >= 0) && (rank_at(win, m_base) < rank_at(first_hit(blk, m_base), m_base));
    endfunction

    task automatic step(string tag, logic [7:0] rq, logic [7:0] mk, logic ae,
                        logic ra, logic sm, logic ns, logic ms, logic [4:0] vb,
                        logic ak, logic cv, logic [2:0] op, logic [2:0] ln);
        int win, top, e_line;
        bit due;
        logic [7:0] n_isr;
        int n_base;
        req_i = rq; mask_i = mk; auto_eoi_i = ae; rot_aeoi_i = ra;
        spec_mask_i = sm; nest_skip_i = ns; is_master_i = ms; vec_base_i = vb;
        ack_i = ak; cmd_valid_i = cv; cmd_op_i = op; cmd_line_i = ln;
        due = is_due(rq, mk, sm, ns, ms, win);
        n_isr = m_isr; n_base = m_base;
        e_line = due ? win : 7;
        if (ak) begin
            if (due) begin
                if (!ae) n_isr[win] = 1'b1;
                else if (ra) n_base = (win + 1) % 8;
            end
        end else if (cv) begin
            top = first_hit(m_isr, m_base);
            case (op)
                3'd1: if (top >= 0) n_isr[top] = 1'b0;
                3'd5: if (top >= 0) begin n_isr[top] = 1'b0; n_base = (top + 1) % 8; end
                3'd3: n_isr[ln] = 1'b0;
                3'd7: begin n_isr[ln] = 1'b0; n_base = (ln + 1) % 8; end
                3'd6: n_base = (ln + 1) % 8;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(tag, "irq_o", irq_o, due);
        chk(tag, "isr_o", isr_o, n_isr);
        chk(tag, "prio_base_o", prio_base_o, n_base);
        chk(tag, "ack_valid_o", ack_valid_o, ak);
        if (ak) begin
            chk(tag, "ack_spur_o", ack_spur_o, !due);
            chk(tag, "ack_line_o", ack_line_o, e_line);
            chk(tag, "ack_vec_o", ack_vec_o, {vb, 3'(e_line)});
        end
        m_isr = n_isr; m_base = n_base;
    endtask

    // shorthand: plain modes, vector base 5'h04
    task automatic s0(string tag, logic [7:0] rq, logic [7:0] mk, logic ak,
                      logic cv, logic [2:0] op, logic [2:0] ln);
        step(tag, rq, mk, 0, 0, 0, 0, 0, 5'h04, ak, cv, op, ln);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "irq_o", irq_o, 0);
        chk("R1", "isr_o", isr_o, 0);
        chk("R1", "prio_base_o", prio_base_o, 0);
        chk("R1", "ack_valid_o", ack_valid_o, 0);
        rst = 1'b0;
        s0("R1", 8'h00, 8'h00, 0, 0, 0, 0);
        // R3 masked request is not due, unmasked is
        s0("R3", 8'h10, 8'h10, 0, 0, 0, 0);
        s0("R3", 8'h10, 8'h00, 0, 0, 0, 0);
        // R6 acknowledge line 4, vector 0x24
        s0("R6", 8'h10, 8'h00, 1, 0, 0, 0);
        // R3 same line in service: not due; line 0 outranks
        s0("R3", 8'h10, 8'h00, 0, 0, 0, 0);
        s0("R3", 8'h01, 8'h00, 0, 0, 0, 0);
        // R4 masked in-service line 4 stops blocking line 5
        step("R4", 8'h20, 8'h10, 0, 0, 0, 0, 0, 5'h04, 0, 0, 0, 0);
        step("R4", 8'h20, 8'h10, 0, 0, 1, 0, 0, 5'h04, 0, 0, 0, 0);
        // R8 non-specific end clears line 4
        s0("R8", 8'h00, 8'h00, 0, 1, 3'd1, 0);
        // R5 put line 2 in service, then nested master
        s0("R5", 8'h04, 8'h00, 1, 0, 0, 0);
        step("R5", 8'h04, 8'h00, 0, 0, 0, 1, 1, 5'h04, 0, 0, 0, 0);
        step("R5", 8'h04, 8'h00, 0, 0, 0, 1, 0, 5'h04, 0, 0, 0, 0);
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd3, 3'd2);
        // R10 spurious acknowledge
        s0("R10", 8'h00, 8'h00, 1, 0, 0, 0);
        s0("R10", 8'h0f, 8'h0f, 1, 0, 0, 0);
        // R9 set priority base 6, then R2 line 7 beats line 0
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd6, 3'd5);
        s0("R2", 8'h81, 8'h00, 0, 0, 0, 0);
        s0("R2", 8'h81, 8'h00, 1, 0, 0, 0);
        // R9 idle codes change nothing
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd0, 3'd3);
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd4, 3'd3);
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd2, 3'd3);
        // R9 rotating specific end on line 7
        s0("R9", 8'h00, 8'h00, 0, 1, 3'd7, 3'd7);
        // R7 auto end with rotation
        step("R7", 8'h08, 8'h00, 1, 1, 0, 0, 0, 5'h1f, 1, 0, 0, 0);
        step("R7", 8'h20, 8'h00, 1, 0, 0, 0, 0, 5'h1f, 1, 0, 0, 0);
        // R12 acknowledge and command together
        s0("R12", 8'h02, 8'h00, 1, 1, 3'd6, 3'd3);
        // R8 rotating end clears, then empty rotating end is a no-op
        s0("R8", 8'h00, 8'h00, 0, 1, 3'd5, 0);
        s0("R8", 8'h00, 8'h00, 0, 1, 3'd5, 0);
        s0("R8", 8'h00, 8'h00, 0, 1, 3'd1, 0);
        // R2 R3 R4 R5 R7 R8 R9 random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] q = $urandom;
            logic ak = (r[3:0] < 4'd5);
            logic cv = (r[7:4] < 4'd4);
            step("R2", q[7:0], (r[9:8] == 0) ? q[15:8] : 8'h00,
                 r[10] & r[11], r[12], r[13] & r[14], r[15], r[16],
                 q[20:16], ak, cv, r[19:17], r[22:20]);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule